// File: doc/BRIEF.md
# Interval Timer Host Bus Front End

This block sits between a processor bus and a three-channel interval timer. It accepts an 8-bit data byte, a 2-bit address, an active-low chip select and active-low read and write strobes, all sampled in the system clock domain. Each access is decoded to one of the counter channels or to the control slot. Channel writes become single-cycle load pulses. Writes to the control slot become single-cycle mode-write pulses aimed at the channel named in the byte, or a read-back pulse that all channels see. Channel reads produce a single-cycle read pulse and drive the selected channel's byte back onto the bus.

The control slot is write-only. A read of it leaves the bus undriven, and status reaches the host only through a read-back command. The counting channels themselves are outside this block. They connect through the strobe outputs, the shared captured byte `wr_byte`, and the flat `chan_rdata` input. The host bus is strobe-based and is not a stream, so no valid/ready handshake exists and no back-pressure applies. Every access completes in the cycle it is seen.

Top module: `tmr_bus_if`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no access in progress, `chan_load`, `mode_we`, `rdbk_stb`, `chan_rd` and `bus_oe` are all zero.
- R2: A write with `cs_n` low to address 0, 1 or 2 yields exactly one pulse on `chan_load[address]`, however long `wr_n` stays low. The pulse comes in the cycle after the first clock edge that sees the write. It comes with `wr_byte` equal to the written byte.
- R3: When `cs_n` is high, activity on `rd_n` and `wr_n` is ignored: no strobe output pulses and `bus_oe` stays low.
- R4: A write to address 3 whose bits 7:6 hold 0, 1 or 2 yields exactly one pulse on `mode_we[bits 7:6]` with `wr_byte` equal to the byte. It yields no `chan_load` pulse.
- R5: A write to address 3 whose bits 7:6 hold 3 is a read-back command. It yields exactly one `rdbk_stb` pulse with `wr_byte` equal to the byte, and no `mode_we` pulse.
- R6: While `cs_n` and `rd_n` are both low and the address is 0, 1 or 2, `bus_oe` is high. In that case `bus_dout` equals byte `address` of `chan_rdata`, where byte n is bits 8n+7:8n.
- R7: A read of address 3 leaves `bus_oe` low and produces no `chan_rd` pulse.
- R8: A read of address 0, 1 or 2 yields exactly one pulse on `chan_rd[address]`, one cycle after the first clock edge that sees the read.
- R9: At most one of the write-side strobes (`chan_load`, `mode_we`, `rdbk_stb`) is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select qualifying both strobes |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Slot select: 0..2 channels, 3 control |
| din | input | 8 | Byte written by the host |
| bus_dout | output | 8 | Byte returned to the host |
| bus_oe | output | 1 | Output enable for `bus_dout` |
| chan_rdata | input | 24 | Read bytes of the channels, channel n in bits 8n+7:8n |
| wr_byte | output | 8 | Byte captured on the last accepted write |
| chan_load | output | 3 | One-cycle count-load pulse per channel |
| mode_we | output | 3 | One-cycle mode-write pulse per channel |
| rdbk_stb | output | 1 | One-cycle read-back command pulse to all channels |
| chan_rd | output | 3 | One-cycle read pulse per channel |

## Verification
Some properties are checked on every cycle. Write-side strobes stay exclusive and last one cycle. Any load, mode or read pulse must trace back to a chip-selected strobe and an address from the previous cycle. A read-back pulse must follow a control-slot write carrying code 3. Other behaviour only the bench's sweeps can show: the captured byte matches the written one, the returned byte matches the right channel, a held strobe still gives exactly one pulse, and the control slot stays undriven on reads. The bench covers every slot, every select code and several hold lengths.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;
  localparam int unsigned TMR_DW  = 8;
  localparam int unsigned TMR_NCH = 3;
  localparam int unsigned TMR_AW  = 2;
endpackage

// File: rtl/tmr_strobe_edge.sv
module tmr_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic rise
);
  logic act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign rise = act & ~act_q;
endmodule

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec #(
  parameter int unsigned NCH = 3,
  parameter int unsigned AW  = 2
) (
  input  logic          en,
  input  logic [AW-1:0] sel,
  output logic [NCH-1:0] hit
);
  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign hit[g] = en && (sel == AW'(g));
  end
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 2
) (
  input  logic              rd_act,
  input  logic [AW-1:0]     addr,
  input  logic [NCH*DW-1:0] chan_rdata,
  output logic [DW-1:0]     dout,
  output logic              oe
);
  always_comb begin
    oe   = 1'b0;
    dout = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_act && addr == AW'(i)) begin
        oe   = 1'b1;
        dout = chan_rdata[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
  import tmr_bus_pkg::*;
#(
  parameter int unsigned NCH = TMR_NCH,
  parameter int unsigned DW  = TMR_DW,
  parameter int unsigned AW  = TMR_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_oe,
  input  logic [NCH*DW-1:0] chan_rdata,
  output logic [DW-1:0]     wr_byte,
  output logic [NCH-1:0]    chan_load,
  output logic [NCH-1:0]    mode_we,
  output logic              rdbk_stb,
  output logic [NCH-1:0]    chan_rd
);
  localparam logic [AW-1:0] CTL_SLOT = AW'(NCH);
  localparam logic [AW-1:0] RB_CODE  = {AW{1'b1}};

  logic wr_act, rd_act, wr_rise, rd_rise, is_ctl;
  logic [AW-1:0]  mode_sel;
  logic [NCH-1:0] load_hit, ctl_hit, rd_hit;
  logic           rb_hit;

  assign wr_act   = ~cs_n & ~wr_n;
  assign rd_act   = ~cs_n & ~rd_n;
  assign is_ctl   = (addr == CTL_SLOT);
  assign mode_sel = din[DW-1 -: AW];
  assign rb_hit   = wr_rise & is_ctl & (mode_sel == RB_CODE);

  tmr_strobe_edge u_wr_edge (.clk(clk), .rst_n(rst_n), .act(wr_act), .rise(wr_rise));
  tmr_strobe_edge u_rd_edge (.clk(clk), .rst_n(rst_n), .act(rd_act), .rise(rd_rise));

  tmr_addr_dec #(.NCH(NCH), .AW(AW)) u_load_dec (
    .en(wr_rise & ~is_ctl), .sel(addr), .hit(load_hit));
  tmr_addr_dec #(.NCH(NCH), .AW(AW)) u_mode_dec (
    .en(wr_rise & is_ctl), .sel(mode_sel), .hit(ctl_hit));
  tmr_addr_dec #(.NCH(NCH), .AW(AW)) u_rd_dec (
    .en(rd_rise), .sel(addr), .hit(rd_hit));

  tmr_rd_mux #(.NCH(NCH), .DW(DW), .AW(AW)) u_rd_mux (
    .rd_act(rd_act), .addr(addr), .chan_rdata(chan_rdata),
    .dout(bus_dout), .oe(bus_oe));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_load <= '0;
      mode_we   <= '0;
      rdbk_stb  <= 1'b0;
      chan_rd   <= '0;
      wr_byte   <= '0;
    end else begin
      chan_load <= load_hit;
      mode_we   <= ctl_hit;
      rdbk_stb  <= rb_hit;
      chan_rd   <= rd_hit;
      if (wr_rise) wr_byte <= din;
    end
  end

  // R2
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_load != '0) |=> (chan_load == '0));
  // R3
  wr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({chan_load, mode_we, rdbk_stb} != '0) |-> $past(!cs_n && !wr_n));
  // R4
  mode_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we != '0) |-> $past(addr == CTL_SLOT && din[DW-1 -: AW] != RB_CODE));
  // R5
  rb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdbk_stb |-> $past(addr == CTL_SLOT && din[DW-1 -: AW] == RB_CODE));
  // R8
  rd_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rd != '0) |-> $past(!cs_n && !rd_n && addr != CTL_SLOT));
  // R9
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chan_load, mode_we, rdbk_stb}));
endmodule

// File: tb/tmr_bus_if_tb.sv
`timescale 1ns/1ps
module tmr_bus_if_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  bus_dout, wr_byte;
  logic        bus_oe, rdbk_stb;
  logic [23:0] chan_rdata = '0;
  logic [2:0]  chan_load, mode_we, chan_rd;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  tmr_bus_if u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .chan_rdata(chan_rdata), .wr_byte(wr_byte), .chan_load(chan_load),
    .mode_we(mode_we), .rdbk_stb(rdbk_stb), .chan_rd(chan_rd));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic csn, input logic [1:0] a, input logic [7:0] d, input int hold);
    int nl = 0, nm = 0, nr = 0;
    logic [2:0] ml = '0, mm = '0;
    logic [7:0] wd = '0;
    string tag;
    @(negedge clk);
    cs_n = csn; wr_n = 1'b0; addr = a; din = d;
    for (int c = 0; c < hold + 2; c++) begin
      @(posedge clk); @(negedge clk);
      nl += $countones(chan_load); nm += $countones(mode_we); nr += int'(rdbk_stb);
      ml |= chan_load; mm |= mode_we;
      if (|{chan_load, mode_we, rdbk_stb}) wd = wr_byte;
      if (c == hold - 1) begin wr_n = 1'b1; cs_n = 1'b1; din = ~d; end
    end
    if (csn) begin
      chk(nl + nm + nr == 0, "R3 write ignored", nl + nm + nr, 0);
    end else if (a != 2'd3) begin
      chk(nl == 1 && ml == (3'b1 << a), "R2 load pulse", {nl[15:0], 13'd0, ml}, {16'd1, 13'd0, 3'b1 << a});
      chk(wd == d, "R2 captured byte", wd, d);
      chk(nm + nr == 0, "R2 no mode/readback", nm + nr, 0);
    end else if (d[7:6] != 2'd3) begin
      chk(nm == 1 && mm == (3'b1 << d[7:6]), "R4 mode pulse", {nm[15:0], 13'd0, mm}, {16'd1, 13'd0, 3'b1 << d[7:6]});
      chk(wd == d, "R4 captured byte", wd, d);
      chk(nl + nr == 0, "R4 no load/readback", nl + nr, 0);
    end else begin
      chk(nr == 1, "R5 readback pulse", nr, 1);
      chk(wd == d, "R5 captured byte", wd, d);
      chk(nl + nm == 0, "R5 no mode/load", nl + nm, 0);
    end
    tag = "";
  endtask

  task automatic do_rd(input logic csn, input logic [1:0] a, input int hold);
    int np = 0;
    logic [2:0] mr = '0;
    logic [7:0] expb;
    @(negedge clk);
    cs_n = csn; rd_n = 1'b0; addr = a;
    #1;
    expb = chan_rdata[a*8 +: 8];
    if (csn) chk(!bus_oe, "R3 read ignored oe", bus_oe, 0);
    else if (a == 2'd3) chk(!bus_oe, "R7 control slot undriven", bus_oe, 0);
    else chk(bus_oe && bus_dout == expb, "R6 read data", {bus_oe, bus_dout}, {1'b1, expb});
    for (int c = 0; c < hold + 2; c++) begin
      @(posedge clk); @(negedge clk);
      np += $countones(chan_rd); mr |= chan_rd;
      if (c == hold - 1) begin rd_n = 1'b1; cs_n = 1'b1; end
    end
    if (csn || a == 2'd3) chk(np == 0, "R7/R3 no read pulse", np, 0);
    else chk(np == 1 && mr == (3'b1 << a), "R8 read pulse", {np[15:0], 13'd0, mr}, {16'd1, 13'd0, 3'b1 << a});
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({chan_load, mode_we, rdbk_stb, chan_rd, bus_oe} == '0, "R1 in reset",
        {chan_load, mode_we, rdbk_stb, chan_rd, bus_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({chan_load, mode_we, rdbk_stb, chan_rd, bus_oe} == '0, "R1 after reset",
        {chan_load, mode_we, rdbk_stb, chan_rd, bus_oe}, 0);
    // R2: channel writes, varied bytes and hold lengths
    for (int a = 0; a < 3; a++)
      for (int d = 0; d < 256; d += 23)
        do_wr(1'b0, 2'(a), 8'(d), 1 + (d % 4));
    // R4 R5: every control byte
    for (int d = 0; d < 256; d++)
      do_wr(1'b0, 2'd3, 8'(d), 1 + (d % 3));
    // R3: deselected writes and reads
    for (int a = 0; a < 4; a++) begin
      do_wr(1'b1, 2'(a), 8'hC5 ^ 8'(a), 2);
      do_rd(1'b1, 2'(a), 2);
    end
    // R6 R7 R8: reads over patterns
    for (int p = 0; p < 8; p++) begin
      chan_rdata = {8'(8'h31 * p + 8'h5A), 8'(8'h17 * p + 8'h0F), 8'(8'hA3 ^ (8'h11 * p))};
      for (int a = 0; a < 4; a++) do_rd(1'b0, 2'(a), 1 + (p % 3));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule